// File: doc/BRIEF.md
# Prefix-Sum Thread Allocation Unit

This block holds a small file of shared global registers and serves atomic fetch-and-add (prefix-sum) requests against it. Many thread contexts send requests at the same time. Each request names a register and an increment. Each requester gets back the value the register held before its own increment was added, and the register keeps the final total. Requests that reach the same register in the same cycle are merged into that one cycle. Each one receives a distinct prefix of the running sum, in fixed port order.

Register 0 acts as the thread-ID dispenser for a parallel section. A spawn loads it with the first ID and records the last valid ID. Contexts that finish a thread request their next ID with an increment of one. A context that receives an ID above the recorded bound is told to go idle. Faster contexts therefore take more threads without any fixed assignment. Once every context reports idle and no request or grant remains in flight, the unit pulses a join and closes the section. A master port writes and reads any register directly.

Top module: `psum_alloc`

## Requirements
- R1: After reset all registers read 0, and no grant, active section or join is signalled.
- R2: A master write changes the addressed register at the next clock edge. The master read port returns the addressed register's current value without delay.
- R3: A request from one port is granted one cycle later. The grant returns the old register value, and the register then holds the old value plus the increment.
- R4: When several ports address the same register in one cycle, port k receives the old value plus the sum of the increments of all requesting ports with a lower index. The register ends at the old value plus all of those increments.
- R5: Requests to different registers in the same cycle are served independently, each against its own register.
- R6: Register arithmetic wraps modulo 2^W.
- R7: For requests to register 0 only bit 0 of the increment is used, so the effective increment is 0 or 1.
- R8: A spawn while no section is active loads register 0 with the lower bound, records the upper bound and makes the section active. A spawn while a section is active has no effect.
- R9: A grant from register 0 whose value exceeds the recorded upper bound carries the over flag.
- R10: While a section is active, the join output pulses for exactly one cycle. The pulse comes one clock after a cycle in which all contexts report idle, no request is present and no grant is outstanding. The section becomes inactive on that same edge.
- R11: When a master write and requests hit the same register in one cycle, the grants still return prefix values based on the old contents, and the master write decides the register's new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_wr_en | input | 1 | Master write strobe |
| m_wr_idx | input | IW | Master write register index |
| m_wr_data | input | W | Master write value |
| m_rd_idx | input | IW | Master read register index |
| m_rd_data | output | W | Master read value |
| spawn | input | 1 | Open a parallel section |
| spawn_lo | input | W | First thread ID |
| spawn_hi | input | W | Last valid thread ID |
| ctx_idle | input | NCTX | Per-context idle report |
| req_vld | input | NCTX | Per-port request valid |
| req_idx | input | NCTX*IW | Per-port register index, port k in bits k*IW upward |
| req_inc | input | NCTX*W | Per-port increment, port k in bits k*W upward |
| gnt_vld | output | NCTX | Per-port grant valid |
| gnt_val | output | NCTX*W | Per-port returned old value |
| gnt_over | output | NCTX | Returned thread ID above the upper bound |
| active | output | 1 | Parallel section open |
| join_done | output | 1 | One-cycle join pulse |

## Verification
The assertions check on every cycle that grants match the previous cycle's requests one for one, and that the over flag appears only with a grant. They also check that a spawn opens a section, and that a join pulse closes the section and appears only after all contexts were idle. The values handed out by a merge cannot be checked per cycle; only the bench's scenarios show them. These include the prefix sums for every requester subset, the masking of the increment on register 0, wraparound, and a master write landing in the same cycle as a merge. The same holds for a complete spawn-to-join run, in which each thread ID is handed out once and a spawn during an active section is ignored.

// File: rtl/psum_alloc.sv
module psum_alloc #(
  parameter int NCTX = 4,
  parameter int NREG = 4,
  parameter int W    = 16,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              m_wr_en,
  input  logic [IW-1:0]     m_wr_idx,
  input  logic [W-1:0]      m_wr_data,
  input  logic [IW-1:0]     m_rd_idx,
  output logic [W-1:0]      m_rd_data,
  input  logic              spawn,
  input  logic [W-1:0]      spawn_lo,
  input  logic [W-1:0]      spawn_hi,
  input  logic [NCTX-1:0]   ctx_idle,
  input  logic [NCTX-1:0]   req_vld,
  input  logic [NCTX*IW-1:0] req_idx,
  input  logic [NCTX*W-1:0] req_inc,
  output logic [NCTX-1:0]   gnt_vld,
  output logic [NCTX*W-1:0] gnt_val,
  output logic [NCTX-1:0]   gnt_over,
  output logic              active,
  output logic              join_done
);
  logic [W-1:0]  rf   [NREG];
  logic [W-1:0]  acc  [NREG];
  logic [W-1:0]  pre  [NCTX];
  logic [W-1:0]  inc  [NCTX];
  logic [IW-1:0] rix  [NCTX];
  logic [W-1:0]  hi_q;
  logic          quiet;

  for (genvar k = 0; k < NCTX; k++) begin : g_port
    assign rix[k] = req_idx[k*IW +: IW];
    assign inc[k] = (rix[k] == '0) ? {{(W-1){1'b0}}, req_inc[k*W]} : req_inc[k*W +: W];
  end

  always_comb begin
    for (int r = 0; r < NREG; r++) acc[r] = rf[r];
    for (int k = 0; k < NCTX; k++) begin
      pre[k] = '0;
      if (req_vld[k]) begin
        pre[k] = acc[rix[k]];
        acc[rix[k]] = acc[rix[k]] + inc[k];
      end
    end
  end

  assign m_rd_data = rf[m_rd_idx];
  assign quiet = active && (&ctx_idle) && !(|req_vld) && !(|gnt_vld);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) rf[r] <= '0;
      hi_q      <= '0;
      active    <= 1'b0;
      join_done <= 1'b0;
      gnt_vld   <= '0;
      gnt_val   <= '0;
      gnt_over  <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) rf[r] <= acc[r];
      if (m_wr_en) rf[m_wr_idx] <= m_wr_data;
      if (spawn && !active) begin
        rf[0]  <= spawn_lo;
        hi_q   <= spawn_hi;
        active <= 1'b1;
      end
      if (quiet) active <= 1'b0;
      join_done <= quiet;
      gnt_vld   <= req_vld;
      for (int k = 0; k < NCTX; k++) begin
        gnt_val[k*W +: W] <= pre[k];
        gnt_over[k] <= req_vld[k] && (rix[k] == '0) && (pre[k] > hi_q);
      end
    end
  end
endmodule

// File: rtl/psum_alloc_chk.sv
module psum_alloc_chk #(
  parameter int NCTX = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            spawn,
  input logic [NCTX-1:0] ctx_idle,
  input logic [NCTX-1:0] req_vld,
  input logic [NCTX-1:0] gnt_vld,
  input logic [NCTX-1:0] gnt_over,
  input logic            active,
  input logic            join_done
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (gnt_vld == '0 && !active && !join_done));
  // R3
  grant_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> gnt_vld == $past(req_vld));
  // R9
  over_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_over & ~gnt_vld) == '0);
  // R8
  spawn_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spawn && !active |=> active);
  // R10
  join_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    join_done |-> !active && $past(active));
  // R10
  join_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    join_done |-> $past(&ctx_idle) && $past(req_vld == '0));
endmodule

bind psum_alloc psum_alloc_chk #(.NCTX(NCTX)) u_chk (.*);

// File: tb/tb_psum_alloc.sv
module tb_psum_alloc;
  localparam int N = 4, R = 4, W = 8, IW = 2;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, m_wr_en, spawn, active, join_done;
  logic [IW-1:0] m_wr_idx, m_rd_idx;
  logic [W-1:0] m_wr_data, m_rd_data, spawn_lo, spawn_hi;
  logic [N-1:0] ctx_idle, req_vld, gnt_vld, gnt_over;
  logic [N*IW-1:0] req_idx;
  logic [N*W-1:0] req_inc, gnt_val;

  psum_alloc #(.NCTX(N), .NREG(R), .W(W)) dut (.*);

  int total = 0, bad = 0;
  logic [W-1:0] mdl [R];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int r = 0; r < R; r++) begin
      m_rd_idx = r[IW-1:0];
      #1 chk(m_rd_data == mdl[r], req, m_rd_data, mdl[r]);
    end
  endtask

  task automatic fire(input logic [N-1:0] v, input int ix[N], input int in[N], input string req);
    logic [W-1:0] eg [N];
    logic [W-1:0] e;
    @(negedge clk);
    req_vld = v;
    for (int k = 0; k < N; k++) begin
      req_idx[k*IW +: IW] = ix[k][IW-1:0];
      req_inc[k*W +: W] = in[k][W-1:0];
      eg[k] = '0;
      if (v[k]) begin
        e = (ix[k] == 0) ? W'(in[k] & 1) : in[k][W-1:0];
        eg[k] = mdl[ix[k]];
        mdl[ix[k]] = mdl[ix[k]] + e;
      end
    end
    @(posedge clk); #2;
    chk(gnt_vld == v, req, gnt_vld, v);
    for (int k = 0; k < N; k++)
      if (v[k]) chk(gnt_val[k*W +: W] == eg[k], req, gnt_val[k*W +: W], eg[k]);
    @(negedge clk);
    req_vld = '0;
    check_regs(req);
  endtask

  task automatic expect_grants(input logic [W-1:0] b, input logic [N-1:0] ov, input logic [N-1:0] v);
    chk(gnt_vld == v, "R3 thread grant valid", gnt_vld, v);
    for (int k = 0; k < N; k++)
      if (v[k]) chk(gnt_val[k*W +: W] == b + W'(k), "R4 thread ID", gnt_val[k*W +: W], b + W'(k));
    chk((gnt_over & v) == ov, "R9 over flags", gnt_over & v, ov);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ix[N], in[N];
    rst_n = 0; m_wr_en = 0; m_wr_idx = '0; m_wr_data = '0; m_rd_idx = '0;
    spawn = 0; spawn_lo = '0; spawn_hi = '0; ctx_idle = '1;
    req_vld = '0; req_idx = '0; req_inc = '0;
    for (int r = 0; r < R; r++) mdl[r] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk(gnt_vld == '0, "R1 grants", gnt_vld, 0);
    chk(!active, "R1 active", active, 0);
    chk(!join_done, "R1 join", join_done, 0);
    check_regs("R1 regs");

    for (int r = 0; r < R; r++) begin
      @(negedge clk);
      m_wr_en = 1; m_wr_idx = r[IW-1:0]; m_wr_data = W'(8'h11 * (r + 1));
      m_rd_idx = r[IW-1:0];
      #1 chk(m_rd_data == mdl[r], "R2 before edge", m_rd_data, mdl[r]);
      mdl[r] = m_wr_data;
      @(negedge clk); m_wr_en = 0;
      check_regs("R2 write");
    end

    for (int p = 0; p < 3; p++)
      for (int m = 0; m < 16; m++) begin
        for (int k = 0; k < N; k++) begin
          ix[k] = (p == 0) ? 1 : (p == 1) ? (k % 2) + 2 : k;
          in[k] = (m * 7 + k * 29 + p * 50 + 3) & 8'hff;
        end
        fire(m[N-1:0], ix, in, (p == 0) ? "R3 R4 merge" : (p == 1) ? "R5 split" : "R7 reg0 mask");
      end

    @(negedge clk);
    m_wr_en = 1; m_wr_idx = 2; m_wr_data = 8'hfe; mdl[2] = 8'hfe;
    @(negedge clk); m_wr_en = 0;
    ix = '{2, 2, 2, 1}; in = '{1, 3, 0, 0};
    fire(4'b0011, ix, in, "R6 wrap");
    chk(mdl[2] == 8'h02, "R6 wrap total", mdl[2], 8'h02);

    @(negedge clk);
    m_wr_en = 1; m_wr_idx = 3; m_wr_data = 8'h40;
    req_vld = 4'b0011; req_idx = {2'd0, 2'd0, 2'd3, 2'd3}; req_inc = {8'd0, 8'd0, 8'd4, 8'd5};
    @(posedge clk); #2;
    chk(gnt_val[7:0] == mdl[3], "R11 grant0 old", gnt_val[7:0], mdl[3]);
    chk(gnt_val[15:8] == mdl[3] + 8'd5, "R11 grant1 prefix", gnt_val[15:8], mdl[3] + 8'd5);
    @(negedge clk); m_wr_en = 0; req_vld = '0; mdl[3] = 8'h40;
    check_regs("R11 write wins");

    spawn = 1; spawn_lo = 8'd5; spawn_hi = 8'd9; ctx_idle = '0;
    @(posedge clk); #2;
    chk(active, "R8 active", active, 1);
    @(negedge clk); spawn = 0; mdl[0] = 8'd5;
    check_regs("R8 spawn load");
    req_vld = '1; req_idx = '0; req_inc = {4{8'd1}};
    @(posedge clk); #2;
    expect_grants(8'd5, 4'b0000, 4'b1111);
    @(negedge clk);
    spawn = 1; spawn_lo = 8'd100; spawn_hi = 8'd200;
    @(posedge clk); #2;
    expect_grants(8'd9, 4'b1110, 4'b1111);
    @(negedge clk); spawn = 0; req_vld = 4'b0001; ctx_idle = 4'b1110;
    m_rd_idx = 0;
    #1 chk(m_rd_data == 8'd13, "R8 spawn ignored when active", m_rd_data, 13);
    @(posedge clk); #2;
    expect_grants(8'd13, 4'b0001, 4'b0001);
    chk(active, "R10 still active", active, 1);
    @(negedge clk); req_vld = '0; ctx_idle = '1;
    @(posedge clk); #2;
    chk(!join_done, "R10 no join with grant outstanding", join_done, 0);
    @(posedge clk); #2;
    chk(join_done, "R10 join pulse", join_done, 1);
    chk(!active, "R10 section closed", active, 0);
    @(posedge clk); #2;
    chk(!join_done, "R10 single pulse", join_done, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule